// File: doc/BRIEF.md
# Accumulator ALU with Decimal-Adjust Flags

This block is the arithmetic and logic unit of an 8-bit accumulator datapath. Each cycle that `in_valid` is high, it takes four inputs:

- the accumulator value,
- a second operand,
- the current flag byte,
- a 5-bit operation code.

From these it forms the new accumulator and the new flag byte. It registers both, and they appear one clock later. The surrounding pipeline fetches the operand, owns the register file and sequences the instructions. Its only job is to feed this unit and take the results back.

The flag byte packs five flags: sign, zero, auxiliary (half) carry, even parity and carry. The auxiliary-carry rules follow a legacy convention:

- With a carry-in, add with carry uses a lower boundary.
- Subtraction reports "no nibble borrow" rather than "borrow".
- AND takes bit 3 of the OR of its inputs.

Decimal adjust corrects a packed-BCD sum in two nibble steps. It may raise carry but never drops it.

Top module: `alu8_core`

## Requirements
- R1: While reset is low, and up to the cycle after it rises, `out_valid`, `acc_out` and `flags_out` are zero. A cycle with `in_valid` high gives its result on the next clock. A cycle with `in_valid` low leaves `acc_out` and `flags_out` unchanged, even when the data inputs change.
- R2: Flag byte layout is: carry bit 0, parity bit 2, auxiliary carry bit 4, zero bit 6, sign bit 7. Every flag-setting op sets sign = result bit 7, zero = (result == 0x00) and parity = 1 for an even count of one bits. Bits 1, 3 and 5 always copy `flags_in`.
- R3: ADD (code 0) and ADC (code 1) form accumulator + operand (+ carry-in for ADC). Carry is bit 8 of the sum. Auxiliary carry is set when the low-nibble sum exceeds 0xF. For ADC with carry-in 1, the threshold instead is a low-nibble sum of 0xF or more.
- R4: SUB (code 2) and SBB (code 3) form accumulator - operand (- carry-in for SBB). Carry is set when the result byte is >= the old accumulator and the operand is nonzero; for SBB, the operand ORed with carry-in must be nonzero. Auxiliary carry is set when the operand low nibble is <= the accumulator low nibble, or strictly < for SBB with carry-in 1.
- R5: CMP (code 4) sets all flags exactly as SUB would, and returns the accumulator unchanged.
- R6: AND (code 5) sets auxiliary carry to bit 3 of (accumulator OR operand) and clears carry. OR (code 6) and XOR (code 7) clear both auxiliary carry and carry.
- R7: INC (code 8) and DEC (code 9) add or subtract one and keep carry. INC sets auxiliary carry when the low nibble was 0xF. DEC sets it when the low nibble was nonzero.
- R8: The rotate codes are: 10 rotates left, 11 rotates right, 12 rotates left through carry and 13 rotates right through carry. Carry takes the bit shifted out, and all other flags are kept.
- R9: DAA (code 17) works in two steps. First, if the low nibble exceeds 9 or auxiliary carry is set, it adds 0x06; auxiliary carry becomes the nibble overflow, and carry is set if the byte overflows. Second, if the resulting high nibble exceeds 9 or carry is set, it adds 0x60 and sets carry on overflow. Carry is never cleared.
- R10: CMA (code 14) inverts the accumulator and keeps all flags. CMC (code 15) toggles only bit 0. STC (code 16) sets only bit 0. Both CMC and STC keep the accumulator.
- R11: Codes 18 to 31 return the accumulator and the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Perform an operation this cycle |
| op_code | input | 5 | Operation code |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Result registers hold a new result |
| acc_out | output | 8 | New accumulator |
| flags_out | output | 8 | New flag byte |

## Verification
The unit holds no state across operations other than its output registers. A wrong result therefore shows on `acc_out` or `flags_out` exactly one clock after the offending input. It also stays there until the next valid cycle, so the defect can be traced to that single operation.

The scarce patterns get directed vectors, because a fault in them would show only there:
- a nibble-boundary auxiliary carry that is off by one with the carry-in,
- subtraction carry with a zero operand,
- decimal adjust when step one overflows or carry arrives already set.

Random vectors over all 32 codes cover the remainder.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW    = 8;
  localparam int NW    = DW / 2;
  localparam int OPW   = 5;
  localparam int FLG_C  = 0;
  localparam int FLG_P  = 2;
  localparam int FLG_AC = 4;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_CMC = 5'd15,
    OP_STC = 5'd16, OP_DAA = 5'd17
  } alu_op_e;

  // Refresh sign, zero and parity from a result byte, keeping other bits.
  function automatic logic [DW-1:0] set_szp(logic [DW-1:0] base, logic [DW-1:0] val);
    logic [DW-1:0] f;
    f         = base;
    f[FLG_S]  = val[DW-1];
    f[FLG_Z]  = (val == '0);
    f[FLG_P]  = ~^val;
    return f;
  endfunction
endpackage

// File: rtl/alu8_rst_sync.sv
module alu8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e        op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [DW-1:0]  fin,
  output logic [DW-1:0]  res,
  output logic [DW-1:0]  fout,
  output logic           hit
);
  logic          cin;
  logic [NW:0]   lo_sum;
  logic [DW:0]   sum;
  logic [DW-1:0] dif;
  logic [DW-1:0] fval;
  logic [DW-1:0] fl;

  always_comb begin
    cin    = fin[FLG_C];
    lo_sum = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]};
    sum    = '0;
    dif    = '0;
    fl     = fin;
    res    = a;
    fval   = a;
    hit    = 1'b1;
    unique case (op)
      OP_ADD: begin
        sum        = {1'b0, a} + {1'b0, b};
        res        = sum[DW-1:0];
        fval       = res;
        fl[FLG_C]  = sum[DW];
        fl[FLG_AC] = (lo_sum > 5'd15);
      end
      OP_ADC: begin
        sum        = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        res        = sum[DW-1:0];
        fval       = res;
        fl[FLG_C]  = sum[DW];
        fl[FLG_AC] = cin ? (lo_sum >= 5'd15) : (lo_sum > 5'd15);
      end
      OP_SUB, OP_CMP: begin
        dif        = a - b;
        fval       = dif;
        res        = (op == OP_CMP) ? a : dif;
        fl[FLG_C]  = (dif >= a) && (b != '0);
        fl[FLG_AC] = (b[NW-1:0] <= a[NW-1:0]);
      end
      OP_SBB: begin
        dif        = a - b - {{(DW-1){1'b0}}, cin};
        fval       = dif;
        res        = dif;
        fl[FLG_C]  = (dif >= a) && ((b | {{(DW-1){1'b0}}, cin}) != '0);
        fl[FLG_AC] = cin ? (b[NW-1:0] < a[NW-1:0]) : (b[NW-1:0] <= a[NW-1:0]);
      end
      OP_INC: begin
        res        = a + 1'b1;
        fval       = res;
        fl[FLG_AC] = (a[NW-1:0] == '1);
      end
      OP_DEC: begin
        res        = a - 1'b1;
        fval       = res;
        fl[FLG_AC] = (a[NW-1:0] != '0);
      end
      default: hit = 1'b0;
    endcase
    fout = set_szp(fl, fval);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  alu_op_e        op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [DW-1:0]  fin,
  output logic [DW-1:0]  res,
  output logic [DW-1:0]  fout,
  output logic           hit
);
  logic          cin;
  logic [DW-1:0] fl;

  always_comb begin
    cin  = fin[FLG_C];
    res  = a;
    fl   = fin;
    fout = fin;
    hit  = 1'b1;
    unique case (op)
      OP_AND: begin
        res        = a & b;
        fl[FLG_AC] = a[3] | b[3];
        fl[FLG_C]  = 1'b0;
        fout       = set_szp(fl, res);
      end
      OP_OR, OP_XOR: begin
        res        = (op == OP_OR) ? (a | b) : (a ^ b);
        fl[FLG_AC] = 1'b0;
        fl[FLG_C]  = 1'b0;
        fout       = set_szp(fl, res);
      end
      OP_RLC: begin
        res         = {a[DW-2:0], a[DW-1]};
        fout[FLG_C] = a[DW-1];
      end
      OP_RRC: begin
        res         = {a[0], a[DW-1:1]};
        fout[FLG_C] = a[0];
      end
      OP_RAL: begin
        res         = {a[DW-2:0], cin};
        fout[FLG_C] = a[DW-1];
      end
      OP_RAR: begin
        res         = {cin, a[DW-1:1]};
        fout[FLG_C] = a[0];
      end
      OP_CMA: res = ~a;
      OP_CMC: fout[FLG_C] = ~cin;
      OP_STC: fout[FLG_C] = 1'b1;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] fin,
  output logic [DW-1:0] res,
  output logic [DW-1:0] fout
);
  logic [DW+1:0] step1;
  logic [DW+1:0] step2;
  logic          fix_lo;
  logic          fix_hi;
  logic          c1;
  logic          c2;
  logic          ac;
  logic [NW:0]   lo6;

  always_comb begin
    fix_lo = (a[NW-1:0] > 4'd9) || fin[FLG_AC];
    lo6    = {1'b0, a[NW-1:0]} + 5'd6;
    ac     = fix_lo ? lo6[NW] : fin[FLG_AC];
    step1  = {2'b00, a} + (fix_lo ? 10'h006 : 10'h000);
    c1     = fin[FLG_C] | step1[DW];
    fix_hi = (step1[DW-1:NW] > 4'd9) || c1;
    step2  = step1 + (fix_hi ? 10'h060 : 10'h000);
    c2     = c1 | (fix_hi & (|step2[DW+1:DW]));
    res    = step2[DW-1:0];
    fout          = fin;
    fout[FLG_AC]  = ac;
    fout[FLG_C]   = c2;
    fout          = set_szp(fout, res);
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  acc_in,
  input  logic [DW-1:0]  opnd_in,
  input  logic [DW-1:0]  flags_in,
  output logic           out_valid,
  output logic [DW-1:0]  acc_out,
  output logic [DW-1:0]  flags_out
);
  alu_op_e       op_e;
  logic          rst_n_int;
  logic [DW-1:0] ar_res, ar_flg, bo_res, bo_flg, da_res, da_flg;
  logic          ar_hit, bo_hit;
  logic [DW-1:0] acc_nx, flg_nx;
  logic [DW-1:0] acc_d, flg_d, acc_q, flg_q;
  logic          vld_d, vld_q;

  assign op_e = alu_op_e'(op_code);

  alu8_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  alu8_arith u_arith (
    .op(op_e), .a(acc_in), .b(opnd_in), .fin(flags_in),
    .res(ar_res), .fout(ar_flg), .hit(ar_hit)
  );

  alu8_bitops u_bitops (
    .op(op_e), .a(acc_in), .b(opnd_in), .fin(flags_in),
    .res(bo_res), .fout(bo_flg), .hit(bo_hit)
  );

  alu8_decadj u_decadj (
    .a(acc_in), .fin(flags_in), .res(da_res), .fout(da_flg)
  );

  // Result select
  always_comb begin
    if (ar_hit) begin
      acc_nx = ar_res;
      flg_nx = ar_flg;
    end else if (bo_hit) begin
      acc_nx = bo_res;
      flg_nx = bo_flg;
    end else if (op_e == OP_DAA) begin
      acc_nx = da_res;
      flg_nx = da_flg;
    end else begin
      acc_nx = acc_in;
      flg_nx = flags_in;
    end
  end

  // Next state with explicit clock enable
  always_comb begin
    vld_d = in_valid;
    acc_d = in_valid ? acc_nx : acc_q;
    flg_d = in_valid ? flg_nx : flg_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q <= 1'b0;
      acc_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid = vld_q;
  assign acc_out   = acc_q;
  assign flags_out = flg_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [OPW-1:0] op_code,
  input logic [DW-1:0]  acc_in,
  input logic [DW-1:0]  opnd_in,
  input logic [DW-1:0]  flags_in,
  input logic           out_valid,
  input logic [DW-1:0]  acc_out,
  input logic [DW-1:0]  flags_out
);
  // R1
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(acc_out) && $stable(flags_out)));

  // R2
  szp_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op_code) <= 5'd9) && ($past(op_code) != 5'd4))
      |-> (flags_out[FLG_Z] == (acc_out == '0) && flags_out[FLG_S] == acc_out[DW-1]
           && flags_out[FLG_P] == ~^acc_out));

  // R2
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flags_out[5] == $past(flags_in[5]) && flags_out[3] == $past(flags_in[3])
                   && flags_out[1] == $past(flags_in[1])));

  // R5
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code) == 5'd4) |-> acc_out == $past(acc_in));

  // R6
  logic_carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code) >= 5'd5 && $past(op_code) <= 5'd7) |-> !flags_out[FLG_C]);

  // R7
  incdec_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(op_code) == 5'd8 || $past(op_code) == 5'd9))
      |-> flags_out[FLG_C] == $past(flags_in[FLG_C]));

  // R8
  rotate_flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code) >= 5'd10 && $past(op_code) <= 5'd13)
      |-> flags_out[DW-1:1] == $past(flags_in[DW-1:1]));

  // R9
  daa_carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code) == 5'd17 && $past(flags_in[FLG_C])) |-> flags_out[FLG_C]);

  // R10
  cma_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code) == 5'd14)
      |-> (acc_out == ~$past(acc_in) && flags_out == $past(flags_in)));

  // R11
  spare_op_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code) >= 5'd18)
      |-> (acc_out == $past(acc_in) && flags_out == $past(flags_in)));

  logic unused_opnd;
  assign unused_opnd = ^opnd_in;
endmodule

bind alu8_core alu8_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
  .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
  .out_valid(out_valid), .acc_out(acc_out), .flags_out(flags_out)
);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [4:0] op_code;
  logic [7:0] acc_in, opnd_in, flags_in;
  logic       out_valid;
  logic [7:0] acc_out, flags_out;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] acc;
    logic [7:0] flg;
    string      req;
  } exp_t;
  exp_t sb_q[$];
  logic [7:0] last_acc = 8'h00;
  logic [7:0] last_flg = 8'h00;

  always #5 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
    .out_valid(out_valid), .acc_out(acc_out), .flags_out(flags_out)
  );

  function automatic string req_of(int op);
    if (op <= 1)  return "R3";
    if (op <= 3)  return "R4";
    if (op == 4)  return "R5";
    if (op <= 7)  return "R6";
    if (op <= 9)  return "R7";
    if (op <= 13) return "R8";
    if (op <= 16) return "R10";
    if (op == 17) return "R9";
    return "R11";
  endfunction

  // Independent reference: returns {acc, flags}
  function automatic logic [15:0] model(int op, int a, int b, int f);
    int c = f & 1, ac = (f >> 4) & 1, r = a, fv = 0, upd = 0, t, nf;
    case (op)
      0: begin t = a + b; ac = ((a & 15) + (b & 15)) > 15; c = t > 255; r = t & 255; fv = r; upd = 1; end
      1: begin t = a + b + c; ac = c ? (((a & 15) + (b & 15)) >= 15) : (((a & 15) + (b & 15)) > 15);
               c = t > 255; r = t & 255; fv = r; upd = 1; end
      2, 4: begin t = (a - b) & 255; c = (t >= a) && (b != 0); ac = (b & 15) <= (a & 15);
               fv = t; r = (op == 4) ? a : t; upd = 1; end
      3: begin t = (a - b - c) & 255; ac = c ? ((b & 15) < (a & 15)) : ((b & 15) <= (a & 15));
               c = (t >= a) && ((b | c) != 0); r = t; fv = t; upd = 1; end
      5: begin ac = ((a | b) >> 3) & 1; c = 0; r = a & b; fv = r; upd = 1; end
      6: begin ac = 0; c = 0; r = a | b; fv = r; upd = 1; end
      7: begin ac = 0; c = 0; r = a ^ b; fv = r; upd = 1; end
      8: begin ac = (a & 15) == 15; r = (a + 1) & 255; fv = r; upd = 1; end
      9: begin ac = (a & 15) != 0; r = (a - 1) & 255; fv = r; upd = 1; end
      10: begin c = a >> 7; r = ((a << 1) | (a >> 7)) & 255; end
      11: begin c = a & 1; r = ((a >> 1) | (a << 7)) & 255; end
      12: begin r = ((a << 1) | c) & 255; c = a >> 7; end
      13: begin r = (a >> 1) | (c << 7); c = a & 1; end
      14: r = (~a) & 255;
      15: c = c ^ 1;
      16: c = 1;
      17: begin
        t = a;
        if ((t & 15) > 9 || ac != 0) begin
          ac = ((t & 15) + 6) > 15; t = t + 6; if (t > 255) c = 1;
        end
        if (((t & 240) > 144) || c != 0) begin
          t = t + 96; if (t > 255) c = 1;
        end
        r = t & 255; fv = r; upd = 1;
      end
      default: ;
    endcase
    nf = (f & 8'hEE) | (ac << 4) | c;
    if (upd != 0) begin
      nf = nf & 8'h3B;
      if (fv & 128) nf = nf | 128;
      if (fv == 0) nf = nf | 64;
      if (($countones(fv[7:0]) % 2) == 0) nf = nf | 4;
    end
    return {r[7:0], nf[7:0]};
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic drive(int op, int a, int b, int f);
    logic [15:0] m;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    op_code  = op[4:0];
    acc_in   = a[7:0];
    opnd_in  = b[7:0];
    flags_in = f[7:0];
    m = model(op, a, b, f);
    e.acc = m[15:8];
    e.flg = m[7:0];
    e.req = req_of(op);
    sb_q.push_back(e);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compares each produced result against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && out_valid) begin
        if (sb_q.size() == 0) begin
          checks++; bad++;
          $display("FAIL R1 unexpected result: actual=%02h expected=none", acc_out);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.req, "acc", acc_out, e.acc);
          check(e.req, "flags", flags_out, e.flg);
          last_acc = acc_out;
          last_flg = flags_out;
        end
      end
    end
  end

  initial begin
    #(50000 * 10);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0;
    acc_in = 8'hA5; opnd_in = 8'h5A; flags_in = 8'hFF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset valid", {7'd0, out_valid}, 8'h00);
    check("R1", "reset acc", acc_out, 8'h00);
    check("R1", "reset flags", flags_out, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "post-reset valid", {7'd0, out_valid}, 8'h00);

    // R3 add boundaries
    drive(0, 8'h0F, 8'h01, 8'h00);
    drive(0, 8'hFF, 8'h01, 8'h00);
    drive(1, 8'h08, 8'h07, 8'h01);
    drive(1, 8'h08, 8'h07, 8'h00);
    drive(1, 8'hFF, 8'h00, 8'h01);
    // R4 subtract boundaries
    drive(2, 8'h10, 8'h01, 8'h00);
    drive(2, 8'h37, 8'h00, 8'h01);
    drive(2, 8'h05, 8'h05, 8'h00);
    drive(3, 8'h00, 8'h00, 8'h01);
    drive(3, 8'h35, 8'h25, 8'h01);
    drive(3, 8'h35, 8'h25, 8'h00);
    // R5 compare
    drive(4, 8'h40, 8'h41, 8'h00);
    drive(4, 8'h41, 8'h41, 8'h00);
    // R6 logic
    drive(5, 8'hF0, 8'h08, 8'h01);
    drive(5, 8'hF0, 8'h07, 8'h11);
    drive(6, 8'h00, 8'h00, 8'h11);
    drive(7, 8'h5A, 8'h5A, 8'h11);
    // R7 inc/dec
    drive(8, 8'hFF, 8'h00, 8'h01);
    drive(8, 8'h0F, 8'h00, 8'h00);
    drive(9, 8'h00, 8'h00, 8'h00);
    drive(9, 8'h10, 8'h00, 8'h01);
    // R8 rotates
    drive(10, 8'h81, 8'h00, 8'h00);
    drive(11, 8'h81, 8'h00, 8'hFE);
    drive(12, 8'h40, 8'h00, 8'h01);
    drive(13, 8'h02, 8'h00, 8'h01);
    // R10 accumulator/carry ops
    drive(14, 8'h3C, 8'h00, 8'hD5);
    drive(15, 8'h3C, 8'h00, 8'hD5);
    drive(16, 8'h3C, 8'h00, 8'h00);
    // R9 decimal adjust
    drive(17, 8'h9B, 8'h00, 8'h00);
    drive(17, 8'h12, 8'h00, 8'h01);
    drive(17, 8'hFA, 8'h00, 8'h00);
    drive(17, 8'h09, 8'h00, 8'h10);
    drive(17, 8'h45, 8'h00, 8'h00);
    // R11 spare codes; R2 spare flag bits ride along
    drive(20, 8'h77, 8'h11, 8'h2A);
    drive(31, 8'h01, 8'h02, 8'hFF);
    go_idle();
    @(negedge clk);

    // R1 hold while idle
    acc_in = 8'hC3; opnd_in = 8'h3C; op_code = 5'd0; flags_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", "idle hold acc", acc_out, last_acc);
    check("R1", "idle hold flags", flags_out, last_flg);

    // R2 random sweep over all codes
    for (int i = 0; i < 600; i++) begin
      drive(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    end
    go_idle();
    repeat (4) @(negedge clk);
    check("R1", "scoreboard drained", 8'(sb_q.size()), 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule